// File: doc/BRIEF.md
# Postfix Expression Evaluator

This block evaluates arithmetic expressions that arrive as a stream of postfix tokens, one token per handshake. Every token is either a number, an operator or an end marker. Numbers go onto an internal stack built from registers. An operator takes the two most recent entries off the stack, combines them and places the result back on the stack. When the end marker arrives and exactly one entry is left, that entry is presented as the result. The stack is then emptied for the next expression.

The stack keeps a count register that points at its top, and it raises flags when it is completely full and when it is completely empty. Two conditions are fatal. The first is an operator that finds fewer than two entries. The second is a number that arrives when the stack is full. After either one, the block stops taking tokens until reset. An end marker that finds a depth other than one is reported with a one-cycle error pulse. The stack is cleared in that case and the block keeps taking tokens. Every operator finishes in the cycle it is accepted, so the block never stalls a legal stream.

Top module: `rpn_eval`

## Requirements
- R1: While reset is asserted and in the first cycle after it, tok_ready is 1, stk_empty is 1, stk_full is 0, and res_valid, err_underflow, err_overflow and err_depth are all 0.
- R2: A token with tok_kind = 2'b00 is a number. When it is accepted (tok_valid and tok_ready both high at a rising edge), tok_val is pushed and the depth grows by one.
- R3: A number accepted while the stack holds 8 entries does not change the stack. It sets err_overflow, which stays high, and it drives tok_ready low until reset. stk_full stays 1.
- R4: A token with tok_kind = 2'b01 is an operator. If the depth is at least two, the operator removes the top two entries and pushes one result, so the depth drops by one. The entry below the top is the left operand and the top entry is the right operand.
- R5: The operator code sits in tok_val[1:0]: 2'b00 adds, 2'b01 subtracts (left minus right), and 2'b10 or 2'b11 multiplies. Every result is reduced modulo 2^16.
- R6: An operator accepted while the depth is below two does not change the stack. It sets err_underflow, which stays high, and it drives tok_ready low until reset.
- R7: A token with tok_kind = 2'b10 is the end marker. If the depth is exactly one, res_valid is high for exactly the cycle after acceptance and res_data holds the remaining value. The stack is then empty.
- R8: An end marker accepted at any depth other than one pulses err_depth for the next cycle and keeps res_valid low. It empties the stack and leaves tok_ready high.
- R9: stk_empty is 1 exactly when the depth is 0, and stk_full is 1 exactly when the depth is 8.
- R10: A token with tok_kind = 2'b11 is accepted and ignored. It changes neither the stack nor any output.
- R11: The stream 3 4 * 5 6 * + end yields 42, and the stream 4 5 * 6 * 2 3 * + 1 + end yields 127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| tok_valid | input | 1 | A token is offered |
| tok_ready | output | 1 | The block can accept a token (low after a fatal error) |
| tok_kind | input | 2 | Token class: 00 number, 01 operator, 10 end, 11 ignored |
| tok_val | input | 16 | Number value, or operator code in bits [1:0] |
| res_valid | output | 1 | One-cycle pulse: res_data holds a finished result |
| res_data | output | 16 | Value of the finished expression |
| err_underflow | output | 1 | Sticky: an operator found fewer than two entries |
| err_overflow | output | 1 | Sticky: a number arrived at a full stack |
| err_depth | output | 1 | One-cycle pulse: the end marker found a depth other than one |
| stk_full | output | 1 | Stack holds 8 entries |
| stk_empty | output | 1 | Stack holds no entries |

## Verification
An error in the top-of-stack count shows up within one token. The full and empty flags move at the wrong push, an operator raises underflow when it should not, or an end marker pulses err_depth where a result was expected. A wrong entry in storage, or swapped operand order, only appears when an end marker brings the value out on res_data. For this reason the vectors end each expression soon after it starts, and they use subtraction with unequal operands to expose order. Wrapping sums and products are checked against values worked out modulo 2^16.

// File: rtl/rpn_pkg.sv
package rpn_pkg;
  typedef enum logic [1:0] {
    TK_NUM = 2'b00,
    TK_OPR = 2'b01,
    TK_END = 2'b10,
    TK_NOP = 2'b11
  } tok_kind_e;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_MULA = 2'b10,
    OP_MULB = 2'b11
  } op_code_e;
endpackage

// File: rtl/rpn_alu.sv
module rpn_alu #(
  parameter int W = 16
) (
  input  logic [1:0]   op,
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  output logic [W-1:0] res
);
  import rpn_pkg::*;
  localparam int PW = 2 * W;

  logic [PW-1:0] prod;
  assign prod = {{W{1'b0}}, lhs} * {{W{1'b0}}, rhs};

  always_comb begin
    unique case (op_code_e'(op))
      OP_ADD:  res = lhs + rhs;
      OP_SUB:  res = lhs - rhs;
      default: res = prod[W-1:0];
    endcase
  end
endmodule

// File: rtl/rpn_stack.sv
module rpn_stack #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  logic            fold,
  input  logic            clr,
  input  logic [W-1:0]    push_data,
  input  logic [W-1:0]    fold_data,
  output logic [W-1:0]    top,
  output logic [W-1:0]    below,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic            full,
  output logic            empty
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] cnt;
  logic [CW-1:0] top_i, below_i;
  logic          wr_en;
  logic [IW-1:0] wr_addr;
  logic [W-1:0]  wr_data;

  assign top_i   = cnt - CW'(1);
  assign below_i = cnt - CW'(2);
  assign top     = mem[top_i[IW-1:0]];
  assign below   = mem[below_i[IW-1:0]];

  // single write port: a push writes above the top, a fold overwrites the left operand slot
  assign wr_en   = push | fold;
  assign wr_addr = push ? cnt[IW-1:0] : below_i[IW-1:0];
  assign wr_data = push ? push_data : fold_data;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (push) cnt <= cnt + CW'(1);
    else if (fold) cnt <= cnt - CW'(1);
  end

  assign count = cnt;
  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst) push |-> !full);
  p_fold_needs_two_r6: assert property (@(posedge clk) disable iff (rst) fold |-> cnt >= CW'(2));
  p_push_grows_r2: assert property (@(posedge clk) disable iff (rst)
    (push && !clr) |=> cnt == $past(cnt) + CW'(1));
  p_fold_shrinks_r4: assert property (@(posedge clk) disable iff (rst)
    (fold && !clr) |=> cnt == $past(cnt) - CW'(1));
  p_one_cmd_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({push, fold, clr}));
endmodule

// File: rtl/rpn_ctrl.sv
module rpn_ctrl #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tok_valid,
  input  logic [1:0]      tok_kind,
  output logic            tok_ready,
  input  logic [$clog2(DEPTH+1)-1:0] count,
  input  logic            full,
  input  logic [W-1:0]    top,
  output logic            push,
  output logic            fold,
  output logic            clr,
  output logic            res_valid,
  output logic [W-1:0]    res_data,
  output logic            err_underflow,
  output logic            err_overflow,
  output logic            err_depth
);
  import rpn_pkg::*;
  localparam int CW = $clog2(DEPTH + 1);

  logic blocked, take, is_num, is_opr, is_end, ovf, unf, single;

  assign tok_ready = !blocked;
  assign take      = tok_valid && !blocked;
  assign is_num    = take && (tok_kind_e'(tok_kind) == TK_NUM);
  assign is_opr    = take && (tok_kind_e'(tok_kind) == TK_OPR);
  assign is_end    = take && (tok_kind_e'(tok_kind) == TK_END);
  assign single    = (count == CW'(1));

  assign ovf  = is_num && full;
  assign unf  = is_opr && (count < CW'(2));
  assign push = is_num && !full;
  assign fold = is_opr && !unf;
  assign clr  = is_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      blocked       <= 1'b0;
      err_overflow  <= 1'b0;
      err_underflow <= 1'b0;
      err_depth     <= 1'b0;
      res_valid     <= 1'b0;
      res_data      <= '0;
    end else begin
      blocked       <= blocked | ovf | unf;
      err_overflow  <= err_overflow | ovf;
      err_underflow <= err_underflow | unf;
      err_depth     <= is_end && !single;
      res_valid     <= is_end && single;
      if (is_end && single) res_data <= top;
    end
  end

  p_stall_sticky_r3: assert property (@(posedge clk) disable iff (rst) !tok_ready |=> !tok_ready);
  p_underflow_stalls_r6: assert property (@(posedge clk) disable iff (rst) err_underflow |-> !tok_ready);
  p_overflow_stalls_r3: assert property (@(posedge clk) disable iff (rst) err_overflow |-> !tok_ready);
  p_result_pulse_r7: assert property (@(posedge clk) disable iff (rst) res_valid |=> !res_valid);
  p_result_xor_depth_r8: assert property (@(posedge clk) disable iff (rst) !(res_valid && err_depth));
endmodule

// File: rtl/rpn_eval.sv
module rpn_eval #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tok_valid,
  output logic         tok_ready,
  input  logic [1:0]   tok_kind,
  input  logic [W-1:0] tok_val,
  output logic         res_valid,
  output logic [W-1:0] res_data,
  output logic         err_underflow,
  output logic         err_overflow,
  output logic         err_depth,
  output logic         stk_full,
  output logic         stk_empty
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          push, fold, clr;
  logic [W-1:0]  top, below, alu_res;
  logic [CW-1:0] count;

  rpn_stack #(.W(W), .DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst(rst), .push(push), .fold(fold), .clr(clr),
    .push_data(tok_val), .fold_data(alu_res),
    .top(top), .below(below), .count(count),
    .full(stk_full), .empty(stk_empty)
  );

  // left operand is the deeper entry
  rpn_alu #(.W(W)) u_alu (
    .op(tok_val[1:0]), .lhs(below), .rhs(top), .res(alu_res)
  );

  rpn_ctrl #(.W(W), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .tok_valid(tok_valid), .tok_kind(tok_kind),
    .tok_ready(tok_ready), .count(count), .full(stk_full), .top(top),
    .push(push), .fold(fold), .clr(clr),
    .res_valid(res_valid), .res_data(res_data),
    .err_underflow(err_underflow), .err_overflow(err_overflow),
    .err_depth(err_depth)
  );

  p_flags_apart_r9: assert property (@(posedge clk) disable iff (rst) !(stk_full && stk_empty));
endmodule

// File: tb/rpn_eval_test.sv
module rpn_eval_test;
  localparam int PERIOD = 10;
  localparam int NV = 43;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tok_valid = 1'b0;
  logic        tok_ready;
  logic [1:0]  tok_kind = 2'b00;
  logic [15:0] tok_val = '0;
  logic        res_valid, err_underflow, err_overflow, err_depth, stk_full, stk_empty;
  logic [15:0] res_data;

  int tests = 0;
  int fails = 0;

  rpn_eval uut (
    .clk(clk), .rst(rst), .tok_valid(tok_valid), .tok_ready(tok_ready),
    .tok_kind(tok_kind), .tok_val(tok_val), .res_valid(res_valid),
    .res_data(res_data), .err_underflow(err_underflow),
    .err_overflow(err_overflow), .err_depth(err_depth),
    .stk_full(stk_full), .stk_empty(stk_empty)
  );

  always #(PERIOD/2) clk = ~clk;

  // {kind, value, expected result on end}
  localparam logic [33:0] VEC [NV] = '{
    {2'd0,16'd3,16'd0},{2'd0,16'd4,16'd0},{2'd1,16'd2,16'd0},{2'd0,16'd5,16'd0},
    {2'd0,16'd6,16'd0},{2'd1,16'd2,16'd0},{2'd1,16'd0,16'd0},{2'd2,16'd0,16'd42},
    {2'd0,16'd4,16'd0},{2'd0,16'd5,16'd0},{2'd1,16'd2,16'd0},{2'd0,16'd6,16'd0},
    {2'd1,16'd2,16'd0},{2'd0,16'd2,16'd0},{2'd0,16'd3,16'd0},{2'd1,16'd2,16'd0},
    {2'd1,16'd0,16'd0},{2'd0,16'd1,16'd0},{2'd1,16'd0,16'd0},{2'd2,16'd0,16'd127},
    {2'd0,16'd10,16'd0},{2'd0,16'd3,16'd0},{2'd1,16'd1,16'd0},{2'd2,16'd0,16'd7},
    {2'd0,16'd3,16'd0},{2'd0,16'd10,16'd0},{2'd1,16'd1,16'd0},{2'd2,16'd0,16'd65529},
    {2'd0,16'd300,16'd0},{2'd0,16'd300,16'd0},{2'd1,16'd2,16'd0},{2'd2,16'd0,16'd24464},
    {2'd0,16'd65535,16'd0},{2'd0,16'd2,16'd0},{2'd1,16'd0,16'd0},{2'd2,16'd0,16'd1},
    {2'd0,16'd5,16'd0},{2'd3,16'h1234,16'd0},{2'd2,16'd0,16'd5},
    {2'd0,16'd7,16'd0},{2'd0,16'd6,16'd0},{2'd1,16'd3,16'd0},{2'd2,16'd0,16'd42}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // drive at negedge, accept at posedge, leave outputs to settle 1 time unit later
  task automatic send(input logic [1:0] k, input logic [15:0] v);
    @(negedge clk);
    tok_valid = 1'b1; tok_kind = k; tok_val = v;
    @(posedge clk);
    #1;
    tok_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    rst = 1'b0;
  endtask

  initial begin
    #(PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 ready in reset", tok_ready, 1);
    check("R1 R9 empty in reset", stk_empty, 1);
    check("R1 errors in reset", {err_underflow, err_overflow, err_depth, res_valid}, 0);
    rst = 1'b0;
    @(posedge clk); #1;
    check("R1 R9 full after reset", stk_full, 0);

    for (int i = 0; i < NV; i++) begin
      send(VEC[i][33:32], VEC[i][31:16]);
      if (VEC[i][33:32] == 2'd2) begin
        check($sformatf("R2 R4 R5 R7 R10 R11 valid vec %0d", i), res_valid, 1);
        check($sformatf("R4 R5 R10 R11 data vec %0d", i), res_data, VEC[i][15:0]);
        check($sformatf("R7 R9 emptied vec %0d", i), stk_empty, 1);
      end
    end
    @(posedge clk); #1;
    check("R7 pulse one cycle", res_valid, 0);
    check("R2 no errors after table", {err_underflow, err_overflow, err_depth}, 0);

    // depth error at depth two
    send(2'd0, 16'd1);
    check("R9 not empty at depth one", stk_empty, 0);
    send(2'd0, 16'd2);
    send(2'd2, 16'd0);
    check("R8 depth pulse", err_depth, 1);
    check("R8 no result", res_valid, 0);
    check("R8 still ready", tok_ready, 1);
    check("R8 stack cleared", stk_empty, 1);
    @(posedge clk); #1;
    check("R8 pulse ends", err_depth, 0);
    send(2'd2, 16'd0);
    check("R8 end on empty", err_depth, 1);

    // overflow
    for (int i = 0; i < 8; i++) send(2'd0, 16'(i + 1));
    check("R9 full at eight", stk_full, 1);
    check("R3 ready at full", tok_ready, 1);
    send(2'd0, 16'd99);
    check("R3 overflow flag", err_overflow, 1);
    check("R3 stalled", tok_ready, 0);
    check("R3 stack unchanged", stk_full, 1);
    send(2'd2, 16'd0);
    check("R3 blocked end ignored", {res_valid, err_depth}, 0);
    do_reset();
    check("R1 overflow cleared by reset", {err_overflow, tok_ready}, 2'b01);

    // underflow
    send(2'd0, 16'd4);
    send(2'd1, 16'd0);
    check("R6 underflow flag", err_underflow, 1);
    check("R6 stalled", tok_ready, 0);
    check("R6 stack unchanged", {stk_empty, stk_full}, 0);
    repeat (3) @(posedge clk); #1;
    check("R6 underflow sticky", err_underflow, 1);
    do_reset();

    // ignored token on empty stack
    send(2'd3, 16'd7);
    check("R10 still empty", stk_empty, 1);
    check("R10 no outputs", {res_valid, err_depth, err_underflow, err_overflow}, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule